// File: doc/BRIEF.md
# Store-Multiple-Word Sequencer

This block carries out a store of a run of general registers to consecutive memory words. A start pulse brings in four values: the index of the first register to store, the index of the base register, that base register's 64-bit value and a signed 16-bit displacement. The block computes the first effective address. It then walks upward from the first register to the last register of the 32-entry file, one register per accepted write. Each write places the low 32 bits of the current register at the current address, and the address then moves forward by four bytes.

The block reads the register file through a combinational read port that it addresses itself. It writes to memory through a valid/ready interface. When the little-endian mode input is high at an accepted start, the block issues no write and raises a fault flag for one cycle. Other logic decides what happens after that fault. The block holds no status or special register and changes none.

Top module: `wordstore_seq`

## Requirements
- R1: An accepted start with first register index F (0..31) produces exactly 32-F accepted writes. They read registers F, F+1, ... 31 in that order, and `rf_raddr_o` shows the register being stored.
- R2: The first write address is B + sext(D). D is the 16-bit displacement, sign-extended to 64 bits. B is `base_val_i`, except that B is zero when `base_idx_i` is 0, whatever `base_val_i` holds.
- R3: Each write's `mem_data_o` equals bits 31:0 (the low-order half, LSB-0 numbering) of the 64-bit register being read.
- R4: After each accepted write that is not the last, the register index rises by 1 and the address rises by 4. The address wraps modulo 2^64.
- R5: If `le_mode_i` is high at an accepted start, no write is issued and `busy_o` stays low. `fault_o` is high for exactly the one cycle after the start.
- R6: While `mem_valid_o` is high and `mem_ready_i` is low, `mem_addr_o`, `mem_data_o` and `rf_raddr_o` hold their values into the next cycle.
- R7: `busy_o` and `mem_valid_o` rise in the cycle after an accepted start and stay high through the last write. In the cycle after the write of register 31 is accepted, `done_o` is high for one cycle and `busy_o` is low.
- R8: A start pulse that arrives while `busy_o` is high is ignored. The running sequence continues unchanged, no fault is raised, and no new sequence starts afterwards.
- R9: A synchronous reset (`rst` high at a clock edge) returns the block to idle, with `busy_o`, `done_o`, `fault_o` and `mem_valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request, one cycle |
| le_mode_i | input | 1 | Core is in little-endian mode (causes a fault at start) |
| first_reg_i | input | 5 | Index of the first register to store |
| base_idx_i | input | 5 | Base register index; 0 selects a zero base |
| base_val_i | input | 64 | Value of the base register |
| disp_i | input | 16 | Signed displacement |
| rf_raddr_o | output | 5 | Register-file read index |
| rf_rdata_i | input | 64 | Register-file read data, same cycle |
| mem_valid_o | output | 1 | Write request valid |
| mem_ready_i | input | 1 | Memory accepts the write this cycle |
| mem_addr_o | output | 64 | Write byte address |
| mem_data_o | output | 32 | Write data word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after the final write |
| fault_o | output | 1 | One-cycle alignment-fault pulse |

## Verification
A start sampled at one rising edge shows up at the very next edge: `busy_o` and the first write become visible there, or `fault_o` does. A write accepted at an edge advances the address and index visible after that same edge. `done_o` appears one edge after the final acceptance and clears at the following edge. The bench drives every input at the falling edge and compares at the next falling edge. Its own model of the index and address moves only in a cycle where it drove ready high, so every comparison falls exactly half a cycle after the edge that should have produced the value.

// File: rtl/wordstore_pkg.sv
package wordstore_pkg;
  localparam int WS_XLEN   = 64;
  localparam int WS_WORD   = 32;
  localparam int WS_NREG   = 32;
  localparam int WS_DISP_W = 16;

  typedef enum logic {
    WS_IDLE = 1'b0,
    WS_XFER = 1'b1
  } ws_state_e;
endpackage

// File: rtl/ws_addr_gen.sv
module ws_addr_gen #(
  parameter int XLEN   = wordstore_pkg::WS_XLEN,
  parameter int NREG   = wordstore_pkg::WS_NREG,
  parameter int DISP_W = wordstore_pkg::WS_DISP_W,
  parameter int STEP   = wordstore_pkg::WS_WORD / 8,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [IDX_W-1:0] first_idx_i,
  input  logic [IDX_W-1:0] base_idx_i,
  input  logic [XLEN-1:0]  base_val_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [XLEN-1:0]  addr_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);

  // Widen the displacement by copying its sign bit.
  function automatic logic [XLEN-1:0] widen_disp(input logic [DISP_W-1:0] d);
    return {{(XLEN-DISP_W){d[DISP_W-1]}}, d};
  endfunction

  // Index 0 means a zero base, not the register's contents.
  function automatic logic [XLEN-1:0] start_addr(input logic [IDX_W-1:0] bidx,
                                                 input logic [XLEN-1:0]  bval,
                                                 input logic [DISP_W-1:0] d);
    logic [XLEN-1:0] base;
    base = (bidx == '0) ? '0 : bval;
    return base + widen_disp(d);
  endfunction

  // Next word address, wrapping at the top of the address space.
  function automatic logic [XLEN-1:0] bump_addr(input logic [XLEN-1:0] a);
    return a + XLEN'(STEP);
  endfunction

  logic [XLEN-1:0]  addr_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      idx_q  <= '0;
    end else if (load_i) begin
      addr_q <= start_addr(base_idx_i, base_val_i, disp_i);
      idx_q  <= first_idx_i;
    end else if (step_i) begin
      addr_q <= bump_addr(addr_q);
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign addr_o = addr_q;
  assign idx_o  = idx_q;
  assign last_o = (idx_q == IDX_W'(NREG - 1));

  AST_STEP_MOVES: assert property (@(posedge clk) disable iff (rst)
    step_i |=> (idx_o == $past(idx_o) + 1'b1) && (addr_o - $past(addr_o) == XLEN'(STEP))) // R4
    else $error("step did not advance index and address");

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !step_i) |=> ($stable(addr_o) && $stable(idx_o))) // R6
    else $error("address or index moved without load or step");

  AST_NO_STEP_PAST_END: assert property (@(posedge clk) disable iff (rst)
    step_i |-> !last_o) // R1
    else $error("step requested beyond last register");

endmodule

// File: rtl/ws_ctrl.sv
module ws_ctrl
  import wordstore_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic le_mode_i,
  input  logic ready_i,
  input  logic last_i,
  output logic busy_o,
  output logic done_o,
  output logic fault_o,
  output logic load_o,
  output logic step_o
);

  ws_state_e state_q;
  logic      launch;
  logic      beat;
  logic      finish;
  logic      le_trap;
  logic      done_q;
  logic      fault_q;

  assign launch  = start_i && (state_q == WS_IDLE);
  assign le_trap = launch && le_mode_i;
  assign beat    = (state_q == WS_XFER) && ready_i;
  assign finish  = beat && last_i;
  assign load_o  = launch && !le_mode_i;
  assign step_o  = beat && !last_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WS_IDLE;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q  <= finish;
      fault_q <= le_trap;
      case (state_q)
        WS_IDLE: if (load_o) state_q <= WS_XFER;
        WS_XFER: if (finish) state_q <= WS_IDLE;
        default: state_q <= WS_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q == WS_XFER);
  assign done_o  = done_q;
  assign fault_o = fault_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o) // R7
    else $error("done lasted more than one cycle");

  AST_LE_TRAPS: assert property (@(posedge clk) disable iff (rst)
    le_trap |=> (fault_o && !busy_o)) // R5
    else $error("little-endian start did not fault cleanly");

  AST_FAULT_IDLE: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> !busy_o) // R5
    else $error("fault while busy");

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !ready_i) |=> (busy_o && !fault_o)) // R8
    else $error("start while busy disturbed the sequence");

endmodule

// File: rtl/wordstore_seq.sv
module wordstore_seq #(
  parameter int XLEN   = wordstore_pkg::WS_XLEN,
  parameter int WORD_W = wordstore_pkg::WS_WORD,
  parameter int NREG   = wordstore_pkg::WS_NREG,
  parameter int DISP_W = wordstore_pkg::WS_DISP_W,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              le_mode_i,
  input  logic [IDX_W-1:0]  first_reg_i,
  input  logic [IDX_W-1:0]  base_idx_i,
  input  logic [XLEN-1:0]   base_val_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [IDX_W-1:0]  rf_raddr_o,
  input  logic [XLEN-1:0]   rf_rdata_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [XLEN-1:0]   mem_addr_o,
  output logic [WORD_W-1:0] mem_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o
);

  logic             load_w;
  logic             step_w;
  logic             last_w;
  logic             busy_w;
  logic [XLEN-1:0]  addr_w;
  logic [IDX_W-1:0] idx_w;
  logic             accept_w;

  ws_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .le_mode_i (le_mode_i),
    .ready_i   (mem_ready_i),
    .last_i    (last_w),
    .busy_o    (busy_w),
    .done_o    (done_o),
    .fault_o   (fault_o),
    .load_o    (load_w),
    .step_o    (step_w)
  );

  ws_addr_gen #(
    .XLEN   (XLEN),
    .NREG   (NREG),
    .DISP_W (DISP_W),
    .STEP   (WORD_W / 8)
  ) u_addr (
    .clk         (clk),
    .rst         (rst),
    .load_i      (load_w),
    .step_i      (step_w),
    .first_idx_i (first_reg_i),
    .base_idx_i  (base_idx_i),
    .base_val_i  (base_val_i),
    .disp_i      (disp_i),
    .addr_o      (addr_w),
    .idx_o       (idx_w),
    .last_o      (last_w)
  );

  assign busy_o      = busy_w;
  assign mem_valid_o = busy_w;
  assign mem_addr_o  = addr_w;
  assign rf_raddr_o  = idx_w;
  assign mem_data_o  = rf_rdata_i[WORD_W-1:0];
  assign accept_w    = mem_valid_o && mem_ready_i;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) && $stable(rf_raddr_o))) // R6
    else $error("write request changed while stalled");

  AST_LAST_GIVES_DONE: assert property (@(posedge clk) disable iff (rst)
    (accept_w && rf_raddr_o == IDX_W'(NREG - 1)) |=> (done_o && !mem_valid_o)) // R7
    else $error("final write not followed by done");

  AST_START_LOADS: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && !le_mode_i) |=> (busy_o && rf_raddr_o == $past(first_reg_i))) // R1
    else $error("start did not begin at the first register");

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o) // R7
    else $error("done while still busy");

endmodule

// File: tb/wordstore_seq_tb_top.sv
module wordstore_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        le_mode_i = 1'b0;
  logic [4:0]  first_reg_i = '0;
  logic [4:0]  base_idx_i = '0;
  logic [63:0] base_val_i = '0;
  logic [15:0] disp_i = '0;
  logic [4:0]  rf_raddr_o;
  logic [63:0] rf_rdata_i;
  logic        mem_valid_o;
  logic        mem_ready_i = 1'b0;
  logic [63:0] mem_addr_o;
  logic [31:0] mem_data_o;
  logic        busy_o, done_o, fault_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk; // 250 MHz

  // Register file contents: upper and lower halves deliberately unrelated.
  function automatic logic [63:0] reg_val(input int i);
    logic [31:0] hi, lo;
    hi = 32'hC0DE_0000 + 32'(i) * 32'h0001_1111;
    lo = 32'h5A3C_0F00 ^ (32'(i) * 32'h0101_0101);
    return {hi, lo};
  endfunction

  assign rf_rdata_i = reg_val(int'(rf_raddr_o));

  wordstore_seq dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .le_mode_i(le_mode_i),
    .first_reg_i(first_reg_i), .base_idx_i(base_idx_i), .base_val_i(base_val_i),
    .disp_i(disp_i), .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i),
    .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i), .mem_addr_o(mem_addr_o),
    .mem_data_o(mem_data_o), .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // One full store sequence; the model steps only on cycles it drove ready.
  task automatic run_op(input int rs, input logic [4:0] bidx, input logic [63:0] bval,
                        input logic [15:0] disp, input int mode, input bit poke);
    logic [63:0] ea;
    int idx;
    int cyc;
    bit fin;
    bit rdy;
    bit stalled;
    ea = ((bidx == 5'd0) ? 64'd0 : bval) + 64'($signed(disp));
    idx = rs; cyc = 0; fin = 0; stalled = 0;
    @(negedge clk);
    start_i = 1'b1; le_mode_i = 1'b0; first_reg_i = 5'(rs);
    base_idx_i = bidx; base_val_i = bval; disp_i = disp; mem_ready_i = 1'b0;
    @(negedge clk);
    while (!fin) begin
      start_i = 1'b0; le_mode_i = 1'b0;
      rdy = (mode == 0) ? 1'b1 : (mode == 1) ? (cyc % 2 == 1) : (cyc % 3 == 0);
      mem_ready_i = rdy;
      chk(mem_valid_o && busy_o, "R7 valid/busy", {62'd0, mem_valid_o, busy_o}, 64'd3);
      chk(mem_addr_o == ea, stalled ? "R6 addr hold" : (idx == rs ? "R2 first addr" : "R4 addr step"),
          mem_addr_o, ea);
      chk(rf_raddr_o == 5'(idx), "R1 reg index", 64'(rf_raddr_o), 64'(idx));
      chk(mem_data_o == reg_val(idx)[31:0], "R3 data low half", 64'(mem_data_o), 64'(reg_val(idx)[31:0]));
      chk(!fault_o && !done_o, "R8 no fault/done mid-run", {62'd0, fault_o, done_o}, 64'd0);
      if (poke && cyc == 1) begin
        start_i = 1'b1; le_mode_i = 1'b1; first_reg_i = 5'((rs + 7) % 32);
      end
      if (rdy) begin
        if (idx == 31) fin = 1;
        else begin idx++; ea = ea + 64'd4; end
      end
      stalled = !rdy;
      cyc++;
      @(negedge clk);
    end
    start_i = 1'b0; le_mode_i = 1'b0; mem_ready_i = 1'b0;
    chk(done_o && !busy_o && !mem_valid_o, "R7 done after last",
        {61'd0, done_o, busy_o, mem_valid_o}, 64'd4);
    chk(cyc >= 32 - rs, "R1 beat count", 64'(cyc), 64'(32 - rs));
    @(negedge clk);
    chk(!done_o, "R7 done single", 64'(done_o), 64'd0);
    chk(!busy_o && !fault_o, "R8 no restart", {62'd0, busy_o, fault_o}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !fault_o && !mem_valid_o, "R9 reset state",
        {60'd0, busy_o, done_o, fault_o, mem_valid_o}, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // Little-endian start faults without writing.
    start_i = 1'b1; le_mode_i = 1'b1; first_reg_i = 5'd5; base_idx_i = 5'd2;
    base_val_i = 64'h1000; disp_i = 16'h0010;
    @(negedge clk);
    start_i = 1'b0; le_mode_i = 1'b0;
    chk(fault_o && !busy_o && !mem_valid_o, "R5 fault pulse",
        {61'd0, fault_o, busy_o, mem_valid_o}, 64'd4);
    @(negedge clk);
    chk(!fault_o && !busy_o && !mem_valid_o, "R5 fault clears",
        {61'd0, fault_o, busy_o, mem_valid_o}, 64'd0);

    // Sweep every first-register index over three address/handshake setups.
    for (int rs = 0; rs < 32; rs++) begin
      run_op(rs, 5'd0, 64'hDEAD_BEEF_0000_1000, 16'h0040, 0, 1'b0);
      run_op(rs, 5'(rs ^ 5), 64'h0000_1000_0000_0000 + 64'(rs * 8), 16'hFFF0, 1, 1'b1);
      run_op(rs, 5'd3, 64'hFFFF_FFFF_FFFF_FFF0, 16'h0008, 2, 1'b0);
    end

    // Reset in the middle of a sequence.
    @(negedge clk);
    start_i = 1'b1; first_reg_i = 5'd0; base_idx_i = 5'd1; base_val_i = 64'h200;
    disp_i = 16'h0; mem_ready_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; mem_ready_i = 1'b0;
    chk(!busy_o && !done_o && !fault_o && !mem_valid_o, "R9 mid-run reset",
        {60'd0, busy_o, done_o, fault_o, mem_valid_o}, 64'd0);
    @(negedge clk);
    chk(!busy_o && !mem_valid_o, "R9 stays idle", {62'd0, busy_o, mem_valid_o}, 64'd0);

    finish_run();
  end
endmodule